// File: doc/BRIEF.md
# Bus-Mapped Down-Counting Timer Bank

This block is a bank of independent 32-bit down-counters behind a zero-wait-state APB slave port. The number of timers is a parameter. Each timer has its own register window, and a separate group of bank-wide registers collects the interrupt state of every timer in one word.

To run a timer, software writes a reload value and then a control word that sets the enable bit. The control word also picks the reload policy and can mask the interrupt. On each cycle where the `tick` input is high, an enabled counter moves down by one. When a tick arrives while the counter reads zero, the counter reloads and the timer's interrupt flag is raised. In periodic mode the reload comes from the load register. In free-running mode the counter reloads all ones, so it can also serve as a continuous count source.

To acknowledge an interrupt, software reads the timer's clear register, or it reads the bank clear register to acknowledge all timers at once. Neither read affects any counter.

Top module: `tmr_bank`

## Requirements
- R1: Timer i has a register window starting at byte address i*0x14, with these offsets: +0x00 is the reload value (read/write), +0x04 is the live count (read-only), +0x08 is control (read/write), +0x0C is the interrupt clear (reads zero), and +0x10 is status. In the control word, bit 0 is enable, bit 1 selects periodic (1) or free-running (0), and bit 2 masks the interrupt (1 = masked). The other control bits read zero.
- R2: A control write that changes enable from 0 to 1 copies the reload value into the counter. The new count is readable from the cycle after that write.
- R3: While enable is 1, each cycle with `tick` high lowers the count by one. The count does not change in cycles where `tick` is low, and it does not change while enable is 0.
- R4: When `tick` is high and an enabled counter reads zero, the counter reloads. It takes the reload value in periodic mode and 32'hFFFFFFFF in free-running mode. In the same clock, the timer's raw interrupt flag is set. No other event sets the flag.
- R5: `irq[i]` equals the raw flag AND NOT the mask bit. Bit 0 of the status register at +0x10 reads the same value. The flag stays set until it is cleared.
- R6: A read of +0x0C clears only that timer's raw flag and leaves its count unchanged.
- R7: If an expiry and a clear fall in the same cycle, the expiry wins and the flag stays set.
- R8: The bank registers are: 0xA0 reads the masked flags, with timer i in bit i; 0xA8 reads the raw flags in the same bit layout; a read of 0xA4 clears every timer's flag and returns zero; 0xAC reads the parameter VERSION (default 32'h3230312A).
- R9: `pready` is always 1 and `pslverr` is always 0. Reads of unmapped addresses return zero. Writes to the live count, status, clear and bank registers have no effect.
- R10: After reset, all registers, counts and flags are zero, and `irq` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer done (always 1) |
| pslverr | output | 1 | Error response (always 0) |
| tick | input | 1 | Single-cycle count enable |
| irq | output | NUM_TIMERS | Per-timer masked interrupt |

## Verification
The collision that matters is a timer expiring in the same clock in which its clear register is read. To provoke it, the bench holds `tick` high on a short periodic reload and issues repeated clear reads separated by varying idle gaps, so that the access phase moves across every phase of the count period. A behavioural model judges every cycle. It counts how many coincidences actually occurred and requires that `irq` stays high after each one. A second overlap is also exercised: a control write that raises enable while `tick` is high. The load must win over any count step in that cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned CNT_W  = 32;
    localparam int unsigned STRIDE = 20;

    localparam int unsigned OFF_LOAD = 0;
    localparam int unsigned OFF_CUR  = 4;
    localparam int unsigned OFF_CTRL = 8;
    localparam int unsigned OFF_CLR  = 12;
    localparam int unsigned OFF_STAT = 16;

    localparam int unsigned BANK_MSTAT = 'hA0;
    localparam int unsigned BANK_CLR   = 'hA4;
    localparam int unsigned BANK_RAW   = 'hA8;
    localparam int unsigned BANK_VER   = 'hAC;

    typedef struct packed {
        logic mask;
        logic periodic;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        ctrl_t            ctrl;
        logic             raw;
    } chan_st_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              tick,
    input  logic              clr_all,
    output logic              rd_hit,
    output logic [CNT_W-1:0]  rd_data,
    output logic              raw,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + STRIDE);

    chan_st_t          st_d, st_q;
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic              expire_d;
    logic              clr_d;

    assign off = addr - LO;
    assign hit = (addr >= LO) && (addr < HI) && (addr[1:0] == 2'b00);

    always_comb begin
        st_d     = st_q;
        expire_d = st_q.ctrl.en && tick && (st_q.cnt == '0);
        if (st_q.ctrl.en && tick) begin
            if (expire_d) begin
                st_d.cnt = st_q.ctrl.periodic ? st_q.load : '1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (acc && wr && hit) begin
            if (off == ADDR_W'(OFF_LOAD)) begin
                st_d.load = wdata;
            end else if (off == ADDR_W'(OFF_CTRL)) begin
                st_d.ctrl.en       = wdata[0];
                st_d.ctrl.periodic = wdata[1];
                st_d.ctrl.mask     = wdata[2];
                if (wdata[0] && !st_q.ctrl.en) begin
                    st_d.cnt = st_q.load;
                end
            end
        end
        clr_d = clr_all || (acc && !wr && hit && (off == ADDR_W'(OFF_CLR)));
        if (expire_d) begin
            st_d.raw = 1'b1;
        end else if (clr_d) begin
            st_d.raw = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw    = st_q.raw;
    assign irq    = st_q.raw && !st_q.ctrl.mask;
    assign rd_hit = hit;

    always_comb begin
        rd_data = '0;
        if (off == ADDR_W'(OFF_LOAD)) begin
            rd_data = st_q.load;
        end else if (off == ADDR_W'(OFF_CUR)) begin
            rd_data = st_q.cnt;
        end else if (off == ADDR_W'(OFF_CTRL)) begin
            rd_data = {{(CNT_W-3){1'b0}}, st_q.ctrl};
        end else if (off == ADDR_W'(OFF_STAT)) begin
            rd_data = {{(CNT_W-1){1'b0}}, irq};
        end
    end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 2,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [31:0] VERSION    = 32'h3230312A
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_TIMERS-1:0]             ch_hit,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  ch_data,
    input  logic [NUM_TIMERS-1:0]             raw_vec,
    input  logic [NUM_TIMERS-1:0]             irq_vec,
    output logic [CNT_W-1:0]                  rdata
);
    localparam int unsigned PAD = CNT_W - NUM_TIMERS;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (ch_hit[i]) begin
                rdata = rdata | ch_data[i];
            end
        end
        if (addr == ADDR_W'(BANK_MSTAT)) begin
            rdata = {{PAD{1'b0}}, irq_vec};
        end else if (addr == ADDR_W'(BANK_RAW)) begin
            rdata = {{PAD{1'b0}}, raw_vec};
        end else if (addr == ADDR_W'(BANK_VER)) begin
            rdata = VERSION;
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 2,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [31:0] VERSION    = 32'h3230312A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic [31:0]           pwdata,
    output logic [31:0]           prdata,
    output logic                  pready,
    output logic                  pslverr,
    input  logic                  tick,
    output logic [NUM_TIMERS-1:0] irq
);
    logic                             acc;
    logic                             clr_all;
    logic [NUM_TIMERS-1:0]            ch_hit;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] ch_data;
    logic [NUM_TIMERS-1:0]            raw_vec;

    assign acc     = psel && penable;
    assign clr_all = acc && !pwrite && (paddr == ADDR_W'(BANK_CLR));
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
        tmr_chan #(
            .ADDR_W (ADDR_W),
            .BASE   (g * STRIDE)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc     (acc),
            .wr      (pwrite),
            .addr    (paddr),
            .wdata   (pwdata),
            .tick    (tick),
            .clr_all (clr_all),
            .rd_hit  (ch_hit[g]),
            .rd_data (ch_data[g]),
            .raw     (raw_vec[g]),
            .irq     (irq[g])
        );
    end

    tmr_rdmux #(
        .NUM_TIMERS (NUM_TIMERS),
        .ADDR_W     (ADDR_W),
        .VERSION    (VERSION)
    ) u_rdmux (
        .addr    (paddr),
        .ch_hit  (ch_hit),
        .ch_data (ch_data),
        .raw_vec (raw_vec),
        .irq_vec (irq),
        .rdata   (prdata)
    );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int unsigned NUM_TIMERS = 2,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [31:0] VERSION    = 32'h3230312A
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  psel,
    input logic                  penable,
    input logic                  pwrite,
    input logic [ADDR_W-1:0]     paddr,
    input logic [31:0]           prdata,
    input logic                  pready,
    input logic                  pslverr,
    input logic                  tick,
    input logic [NUM_TIMERS-1:0] irq
);
    logic acc_rd;
    assign acc_rd = psel && penable && !pwrite;

    p_zero_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> (pready && !pslverr));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr >= ADDR_W'('hB0)) |-> (prdata == '0));

    p_version_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == ADDR_W'('hAC)) |-> (prdata == VERSION));

    p_bank_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && paddr == ADDR_W'('hA4) && !tick) |=> (irq == '0));

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_t
        p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> ($past(tick) || $past(psel && penable && pwrite)));

        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_rd && paddr == ADDR_W'(g * 20 + 12) && !tick) |=> !irq[g]);

        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !(psel && penable)) |=> irq[g]);
    end
endmodule

bind tmr_bank tmr_bank_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .ADDR_W     (ADDR_W),
    .VERSION    (VERSION)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .tick    (tick),
    .irq     (irq)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
    localparam int          CLK_PERIOD = 10;
    localparam int          NT         = 2;
    localparam logic [31:0] VER        = 32'h3230312A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic [NT-1:0] irq;

    int nchk = 0, nfail = 0, coinc_cnt = 0;
    bit tick_rand = 0, coinc = 0;
    int unsigned lfsr = 32'h1ACE5;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_bank u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .tick(tick), .irq(irq)
    );

    // behavioural reference
    logic [31:0] m_cnt [NT];
    logic [31:0] m_load[NT];
    bit m_en[NT], m_per[NT], m_msk[NT], m_raw[NT];

    always @(posedge clk) begin
        coinc = 0;
        for (int i = 0; i < NT; i++) begin
            int b;
            bit fire, clr, acc;
            logic [31:0] nc;
            if (!rst_n) begin
                m_cnt[i] = 0; m_load[i] = 0; m_en[i] = 0; m_per[i] = 0; m_msk[i] = 0; m_raw[i] = 0;
            end else begin
                b    = i * 20;
                acc  = psel && penable;
                fire = m_en[i] && tick && (m_cnt[i] == 0);
                nc   = m_cnt[i];
                if (m_en[i] && tick) nc = fire ? (m_per[i] ? m_load[i] : 32'hFFFF_FFFF) : m_cnt[i] - 1;
                clr = acc && !pwrite && (int'(paddr) == b + 12 || paddr == 8'hA4);
                if (acc && pwrite && int'(paddr) == b) m_load[i] = pwdata;
                if (acc && pwrite && int'(paddr) == b + 8) begin
                    if (pwdata[0] && !m_en[i]) nc = m_load[i];
                    m_en[i] = pwdata[0]; m_per[i] = pwdata[1]; m_msk[i] = pwdata[2];
                end
                if (i == 0 && fire && clr) begin coinc = 1; coinc_cnt++; end
                if (fire) m_raw[i] = 1; else if (clr) m_raw[i] = 0;
                m_cnt[i] = nc;
            end
        end
    end

    function automatic bit m_irq(input int i);
        return m_raw[i] && !m_msk[i];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] v = 0;
        for (int i = 0; i < NT; i++) begin
            int b = i * 20;
            if (int'(a) == b)      v = m_load[i];
            if (int'(a) == b + 4)  v = m_cnt[i];
            if (int'(a) == b + 8)  v = {29'd0, m_msk[i], m_per[i], m_en[i]};
            if (int'(a) == b + 16) v = {31'd0, m_irq(i)};
            if (a == 8'hA0) v[i] = m_irq(i);
            if (a == 8'hA8) v[i] = m_raw[i];
        end
        if (a == 8'hAC) v = VER;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison (R5 irq, R7 collision)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NT; i++)
                check(irq[i] == m_irq(i), "R5 irq vs model", 32'(irq[i]), 32'(m_irq(i)));
            if (coinc) check(irq[0] == 1'b1, "R7 expiry beats clear", 32'(irq[0]), 1);
        end
    end

    always @(negedge clk) begin
        if (tick_rand) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            tick = (lfsr[1:0] != 2'b00);
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input string req, output logic [31:0] d);
        logic [31:0] e;
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1;
        #1;
        d = prdata;
        e = exp_rd(a);
        check(prdata == e, req, prdata, e);
        check(pready && !pslverr, "R9 zero wait no error", {pready, pslverr}, 2'b10);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] d, h1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check(irq == '0, "R10 irq after reset", 32'(irq), 0);
        apb_rd(8'h00, "R10 load reset", d);
        apb_rd(8'h04, "R10 count reset", d);
        apb_rd(8'h08, "R10 ctrl reset", d);
        apb_rd(8'hA8, "R10 raw reset", d);

        // R1 R2 periodic timer 0
        apb_wr(8'h00, 32'd5);
        apb_rd(8'h00, "R1 load readback", d);
        apb_wr(8'h08, 32'h3);
        apb_rd(8'h08, "R1 ctrl readback", d);
        apb_rd(8'h04, "R2 load on enable", d);
        check(d == 32'd5, "R2 count equals load", d, 5);
        tick = 1;
        repeat (3) @(negedge clk);
        apb_rd(8'h04, "R3 countdown", d);
        repeat (10) @(negedge clk);
        tick = 0;
        apb_rd(8'h10, "R5 status", d);
        apb_rd(8'hA8, "R8 raw vector", d);
        apb_rd(8'h04, "R6 count before clear", h1);
        apb_rd(8'h0C, "R6 clear reads zero", d);
        apb_rd(8'h04, "R6 count unchanged", d);
        check(d == h1, "R6 count unchanged by clear", d, h1);
        check(irq[0] == 1'b0, "R6 irq cleared", 32'(irq[0]), 0);

        // R4 free-running timer 1
        apb_wr(8'h14, 32'd2);
        apb_wr(8'h1C, 32'h1);
        tick = 1;
        repeat (4) @(negedge clk);
        tick = 0;
        apb_rd(8'h18, "R4 free-running reload", d);
        check(d >= 32'hFFFF_FF00, "R4 reload all ones", d, 32'hFFFF_FFFF);
        apb_wr(8'h1C, 32'h5);
        apb_rd(8'hA0, "R8 masked vector", d);
        apb_rd(8'hA8, "R8 raw vector masked", d);
        apb_rd(8'h24, "R5 status masked", d);
        apb_rd(8'hA4, "R8 bank clear", d);
        apb_rd(8'hA8, "R8 raw after bank clear", d);

        // R7 collision sweep on timer 0
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h00, 32'd3);
        tick = 1;
        apb_wr(8'h08, 32'h3);
        for (int k = 0; k < 16; k++) begin
            apb_rd(8'h0C, "R7 clear during sweep", d);
            repeat (k % 4) @(negedge clk);
        end
        check(coinc_cnt > 0, "R7 collision provoked", coinc_cnt, 1);

        // R3 random ticks
        tick_rand = 1;
        for (int k = 0; k < 40; k++) begin
            apb_rd(8'h04, "R3 random tick count", d);
            apb_rd(8'h18, "R3 random tick count t1", d);
        end
        tick_rand = 0;
        tick = 1;

        // R9 read-only and unmapped
        apb_wr(8'h04, 32'h1234);
        apb_rd(8'h04, "R9 count write ignored", d);
        apb_wr(8'hA8, 32'hFF);
        apb_rd(8'hA8, "R9 raw write ignored", d);
        apb_rd(8'hB4, "R9 unmapped zero", d);
        apb_rd(8'h30, "R9 unmapped gap zero", d);
        apb_rd(8'hAC, "R8 version", d);

        // R3 disabled hold
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h04, "R3 disabled", h1);
        repeat (5) @(negedge clk);
        apb_rd(8'h04, "R3 disabled hold", d);
        check(d == h1, "R3 count held while disabled", d, h1);
        tick = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule